// File: doc/BRIEF.md
# Asynchronous Handshake Memory Slave with Programmable Acknowledge Delay

This block sits on a 16-bit asynchronous bus as a memory target. A master opens a transfer by driving a word address, the direction line and the active-low address strobe, together with one or both active-low byte strobes. An external decoder supplies an active-high device select. The block holds a small word memory with two byte lanes. Once the address strobe is active, it answers with an active-low transfer acknowledge after a programmed number of wait states.

The acknowledge comes from a short shift register clocked by the system clock. Its serial input is the address strobe combined with the device select. The register is cleared on every clock edge at which the address strobe is inactive. A two-bit wait setting picks the tap that drives the acknowledge, so the same block can model memories of different speeds.

Reads put the addressed word on a separate data-out bus and raise a drive-enable while the acknowledge is active. Writes store the strobed byte lanes at the clock edge that sets the acknowledge.

Top module: `async_mem_slave`

## Requirements
- R1: After reset every memory word reads as zero, the acknowledge is high (negated) and the drive-enable is low.
- R2: With the address strobe low and the device select high, the acknowledge goes low after exactly wait_cfg+1 rising clock edges. wait_cfg runs from 0 to 3. Before that edge it stays high.
- R3: When the address strobe goes high, the acknowledge goes high and the drive-enable goes low with no clock edge in between.
- R4: With the device select low, the acknowledge is never asserted and a write changes no memory word.
- R5: On a read (bus_rnw=1), while the acknowledge is low, rd_oe is 1. In that state rd_data[15:8] carries the upper byte of the word at word_addr if bus_uds_n is low, and rd_data[7:0] carries the lower byte if bus_lds_n is low. A lane whose strobe is high reads as zero. In every other state, rd_oe is 0.
- R6: On a write (bus_rnw=0), bits 15..8 are stored only if bus_uds_n is low, and bits 7..0 are stored only if bus_lds_n is low. The other lane keeps its old value.
- R7: A write takes effect at the rising edge that asserts the acknowledge. A read in the next cycle returns the new value.
- R8: A transfer that follows another after one clock with the address strobe high sees the full wait_cfg+1 edge delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_uds_n | input | 1 | Upper byte strobe (bits 15..8), active low |
| bus_lds_n | input | 1 | Lower byte strobe (bits 7..0), active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| dev_sel | input | 1 | Device select from the address decoder, active high |
| word_addr | input | 8 | Word address |
| wait_cfg | input | 2 | Wait states, 0 to 3 |
| wr_data | input | 16 | Write data from the master |
| rd_data | output | 16 | Read data (zero when not driven) |
| rd_oe | output | 1 | Read-data drive enable |
| ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench runs every wait setting against every non-empty byte-strobe combination. It uses addresses at both ends of the array and in the middle. Each write is followed by full-word and partial-lane reads. The per-clock acknowledge probe separates an off-by-one tap or shift error from a correct delay. The lane mixes separate swapped or merged byte enables. A held strobe with the device select low shows whether the select gates both the acknowledge and the memory. A read of the same address afterwards confirms that nothing was stored.

// File: rtl/async_mem_pkg.sv
package async_mem_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_en_t;

    function automatic logic [LANES*LANE_W-1:0] lane_mask(input lane_en_t en);
        return {{LANE_W{en.hi}}, {LANE_W{en.lo}}};
    endfunction
endpackage

// File: rtl/async_ack_delay.sv
module async_ack_delay #(
    parameter int MAX_WAIT = 3,
    localparam int SRW  = MAX_WAIT + 1,
    localparam int SELW = (SRW > 1) ? $clog2(SRW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_on,
    input  logic            sel_en,
    input  logic [SELW-1:0] wait_sel,
    output logic            ack,
    output logic            ack_set
);
    typedef struct packed {
        logic [SRW-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!strobe_on) begin
            st_d.sr = '0;
        end else begin
            st_d.sr = (st_q.sr << 1) | SRW'(sel_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack     = st_q.sr[wait_sel] & strobe_on & sel_en;
    assign ack_set = st_d.sr[wait_sel] & ~st_q.sr[wait_sel] & strobe_on & sel_en;

    // R2: with no wait state the acknowledge follows one edge of strobe and select
    p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_sel == '0 && $rose(ack)) |-> $past(strobe_on && sel_en));

    // R8: an edge with the strobe off leaves no stale acknowledge
    p_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!strobe_on) |-> !ack);
endmodule

// File: rtl/async_lane_mem.sv
module async_lane_mem
    import async_mem_pkg::*;
#(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_go,
    input  lane_en_t      lanes,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } st_t;

    st_t st_d, st_q;
    logic [LANES-1:0] lane_vec;

    assign lane_vec = {lanes.hi, lanes.lo};

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_vec[l]) begin
                    st_d.mem[addr][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.mem[addr];

    // R6: a lane without its strobe keeps its contents across a write
    p_hi_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !lanes.hi) |=> $stable(st_q.mem[$past(addr)][DW-1 -: LANE_W]));
endmodule

// File: rtl/async_mem_slave.sv
module async_mem_slave
    import async_mem_pkg::*;
#(
    parameter int AW       = 8,
    parameter int MAX_WAIT = 3,
    localparam int DW   = LANES * LANE_W,
    localparam int SELW = (MAX_WAIT + 1 > 1) ? $clog2(MAX_WAIT + 1) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_as_n,
    input  logic            bus_uds_n,
    input  logic            bus_lds_n,
    input  logic            bus_rnw,
    input  logic            dev_sel,
    input  logic [AW-1:0]   word_addr,
    input  logic [SELW-1:0] wait_cfg,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data,
    output logic            rd_oe,
    output logic            ack_n
);
    logic     ack, ack_set, wr_go;
    lane_en_t lanes;
    logic [DW-1:0] mem_word;

    assign lanes.hi = ~bus_uds_n;
    assign lanes.lo = ~bus_lds_n;

    async_ack_delay #(.MAX_WAIT(MAX_WAIT)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_on(~bus_as_n),
        .sel_en   (dev_sel),
        .wait_sel (wait_cfg),
        .ack      (ack),
        .ack_set  (ack_set)
    );

    assign wr_go = ack_set & ~bus_rnw;

    async_lane_mem #(.AW(AW)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (word_addr),
        .wdata(wr_data),
        .wr_go(wr_go),
        .lanes(lanes),
        .rdata(mem_word)
    );

    assign rd_oe   = ack & bus_rnw;
    assign rd_data = rd_oe ? (mem_word & lane_mask(lanes)) : '0;
    assign ack_n   = ~ack;

    // R4: no acknowledge without the device select
    p_no_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel |-> ack_n);

    // R3: strobe off means acknowledge off
    p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n |-> (ack_n && !rd_oe));

    // R5: drive enable only on an acknowledged read
    p_oe_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (bus_rnw && !ack_n));
endmodule

// File: tb/test_async_mem_slave.sv
module test_async_mem_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_as_n = 1'b1, bus_uds_n = 1'b1, bus_lds_n = 1'b1;
    logic        bus_rnw = 1'b1, dev_sel = 1'b0;
    logic [7:0]  word_addr = '0;
    logic [1:0]  wait_cfg = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_oe, ack_n;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] model [256];

    always #10 clk = ~clk;

    async_mem_slave i_async_mem_slave (
        .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
        .bus_lds_n(bus_lds_n), .bus_rnw(bus_rnw), .dev_sel(dev_sel),
        .word_addr(word_addr), .wait_cfg(wait_cfg), .wr_data(wr_data),
        .rd_data(rd_data), .rd_oe(rd_oe), .ack_n(ack_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one transfer; lanes[1]=upper, lanes[0]=lower
    task automatic xfer(input logic rnw, input logic sel, input logic [7:0] a,
                        input logic [1:0] lanes, input logic [1:0] ws,
                        input logic [15:0] d, input int hold);
        int last;
        logic [15:0] m;
        @(negedge clk);
        word_addr = a; bus_rnw = rnw; dev_sel = sel; wait_cfg = ws; wr_data = d;
        bus_as_n = 1'b0; bus_uds_n = ~lanes[1]; bus_lds_n = ~lanes[0];
        last = sel ? int'(ws) + 1 : hold;
        for (int n = 1; n <= last; n++) begin
            @(negedge clk);
            if (sel) begin
                check("R2/R8 ack delay", {31'b0, ack_n}, {31'b0, (n < last)});
            end else begin
                check("R4 ack without select", {31'b0, ack_n}, 32'd1);
            end
        end
        m = {lanes[1] ? 8'hFF : 8'h00, lanes[0] ? 8'hFF : 8'h00};
        if (sel && !rnw) begin
            model[a] = (model[a] & ~m) | (d & m); // R6, R7
        end
        if (sel && rnw) begin
            check("R5 rd_oe during ack", {31'b0, rd_oe}, 32'd1);
            check("R5 read data lanes", {16'b0, rd_data}, {16'b0, model[a] & m});
        end else begin
            check("R5 rd_oe off", {31'b0, rd_oe}, 32'd0);
        end
        bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1;
        #1;
        check("R3 ack release", {31'b0, ack_n}, 32'd1);
        check("R3 oe release", {31'b0, rd_oe}, 32'd0);
        @(negedge clk);
        check("R8 idle ack", {31'b0, ack_n}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 ack after reset", {31'b0, ack_n}, 32'd1);
        check("R1 oe after reset", {31'b0, rd_oe}, 32'd0);
        rst_n = 1'b1;
        xfer(1'b1, 1'b1, 8'd0,   2'b11, 2'd0, 16'h0, 0); // R1
        xfer(1'b1, 1'b1, 8'd255, 2'b11, 2'd3, 16'h0, 0); // R1
        xfer(1'b1, 1'b1, 8'd100, 2'b11, 2'd1, 16'h0, 0); // R1
        for (int ws = 0; ws < 4; ws++) begin
            for (int ln = 1; ln < 4; ln++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [7:0] a;
                    logic [15:0] d;
                    case (k)
                        0: a = 8'd0;
                        1: a = 8'd1;
                        2: a = 8'd127;
                        3: a = 8'd254;
                        4: a = 8'd255;
                        default: a = 8'(ws * 37 + ln * 11 + 3);
                    endcase
                    d = 16'(int'(a) * 257 + ws * 4099 + ln * 13 + k * 771);
                    xfer(1'b0, 1'b1, a, 2'(ln), 2'(ws), d, 0);       // R6 R7
                    xfer(1'b1, 1'b1, a, 2'b11, 2'(ws), 16'h0, 0);    // R5 R7
                    xfer(1'b1, 1'b1, a, 2'(ln), 2'(3 - ws), 16'h0, 0); // R5 lanes
                end
            end
        end
        // R4: held write without the select, then read back
        xfer(1'b0, 1'b0, 8'd5, 2'b11, 2'd0, 16'hBEEF, 6);
        xfer(1'b1, 1'b1, 8'd5, 2'b11, 2'd0, 16'h0, 0);
        xfer(1'b0, 1'b0, 8'd0, 2'b11, 2'd2, 16'h1234, 4);
        xfer(1'b1, 1'b1, 8'd0, 2'b11, 2'd2, 16'h0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule